// File: doc/BRIEF.md
# Peripheral Clock Source, Divider and Gate Controller

This block sets up the clock of a single peripheral inside one reference clock domain. Each candidate source clock is represented by an enable strobe, `src_tick`, that is high for one reference cycle per source period. Software writes three fields through a small register port:

- **Source choice:** a one-hot code that picks which source feeds the peripheral.
- **Divide value:** a value N that divides the chosen source by N+1.
- **Gate code:** a three-bit code that can switch the peripheral clock off.

The block emits a one-cycle clock-enable pulse, `clk_en_o`, for the peripheral.

The requested fields and the fields in effect are kept apart. A new source or divide value is taken over only at the end of the divided period that is running, so no shortened or stretched period is ever produced. The status outputs show the source and divide value that are actually in use, not the requested ones. Only the full code 3'b111 gates the clock. Any other gate code leaves the clock running, so a single upset bit cannot stop it.

Top module: `pclk_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, `clk_en_o` is 0, `src_in_use` is 1 (source 0), `div_in_use` is 0, and all requested fields read back as their reset values (source 1, divide 0, gate 0).
- R2: With a divide value of N in use, `clk_en_o` gives exactly one single-cycle pulse for every N+1 strobes of the selected source.
- R3: With a divide value of 0, every strobe of the selected source yields a pulse on `clk_en_o` in the next cycle.
- R4: Strobes on sources that are not in use have no effect on the divider or on `clk_en_o`.
- R5: A write to the source field (address 0) is accepted only if exactly one of the low NSRC data bits is set and every other data bit is 0. Any other value is discarded, and the previous request is kept.
- R6: Requested source and divide values take effect only on the selected strobe that ends the current divided period. `src_in_use` and `div_in_use` change in the same cycle as the pulse for that strobe.
- R7: While the gate field holds 3'b111, `clk_en_o` stays 0. The divider keeps counting, and period-end updates of the fields in use still happen.
- R8: Any gate code other than 3'b111 leaves `clk_en_o` running.
- R9: Register map:
  - Address 0 holds the requested source in bits [NSRC-1:0].
  - Address 1 holds the requested divide value in bits [DIVW-1:0].
  - Address 2 holds the gate code in bits [2:0].
  - Address 3 is read-only status, with `src_in_use` in [NSRC-1:0] and `div_in_use` in [NSRC+DIVW-1:NSRC].
  - Unused bits read as 0. `rdata` shows the field chosen by `addr` one clock later.
- R10: `src_in_use` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| src_tick | input | NSRC | One enable strobe per source clock |
| clk_en_o | output | 1 | Registered peripheral clock-enable pulse |
| src_in_use | output | NSRC | One-hot source currently in effect |
| div_in_use | output | DIVW | Divide value currently in effect |

## Verification
The hardest situation to reach is a change of request in the middle of a divided period. The old source and divide value must stay in force, and must stay visible on the status ports, until the exact strobe that closes the period. The stimulus sets a divide value, lets one period boundary load it, and then writes a new source and a new divide value. It then sends strobes one at a time, checking that nothing moves before the closing strobe and that both status fields switch together with its pulse. Strobes on the newly requested source, sent before the switch, are also checked to have no effect.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  typedef enum logic [1:0] {
    A_SRC  = 2'd0,
    A_DIV  = 2'd1,
    A_GATE = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;

  localparam int GATEW = 3;
  localparam logic [GATEW-1:0] GATE_OFF_CODE = 3'b111;
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int DIVW = 4,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic [NSRC-1:0]   cur_src,
  input  logic [DIVW-1:0]   cur_div,
  output logic [NSRC-1:0]   req_src,
  output logic [DIVW-1:0]   req_div,
  output logic [GATEW-1:0]  gate_code,
  output logic              gate_off,
  output logic [DW-1:0]     rdata
);
  localparam logic [NSRC-1:0] SRC_RST = NSRC'(1);
  localparam int STATW = NSRC + DIVW;

  logic [NSRC-1:0] src_part;
  logic            upper_clear;
  logic            src_ok;
  logic [DW-1:0]   rd_nxt;

  assign src_part    = wdata[NSRC-1:0];
  assign upper_clear = ((wdata >> NSRC) == '0);
  assign src_ok      = (src_part != '0) && ((src_part & (src_part - 1'b1)) == '0)
                       && upper_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_src   <= SRC_RST;
      req_div   <= '0;
      gate_code <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        A_SRC:   if (src_ok) req_src <= src_part;
        A_DIV:   req_div   <= wdata[DIVW-1:0];
        A_GATE:  gate_code <= wdata[GATEW-1:0];
        default: ;
      endcase
    end
  end

  assign gate_off = (gate_code == GATE_OFF_CODE);

  always_comb begin
    rd_nxt = '0;
    case (reg_addr_e'(addr))
      A_SRC:  rd_nxt[NSRC-1:0]  = req_src;
      A_DIV:  rd_nxt[DIVW-1:0]  = req_div;
      A_GATE: rd_nxt[GATEW-1:0] = gate_code;
      A_STAT: begin
        rd_nxt[NSRC-1:0]      = cur_src;
        rd_nxt[STATW-1:NSRC]  = cur_div;
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/pclk_srcsel.sv
module pclk_srcsel #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] src_tick,
  input  logic [NSRC-1:0] cur_src,
  output logic            sel_tick
);
  logic [NSRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NSRC; i++) begin : g_or
    assign chain[i+1] = chain[i] | (src_tick[i] & cur_src[i]);
  end
  assign sel_tick = chain[NSRC];
endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
  parameter int NSRC = 4,
  parameter int DIVW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_tick,
  input  logic            gate_off,
  input  logic [NSRC-1:0] req_src,
  input  logic [DIVW-1:0] req_div,
  output logic [NSRC-1:0] cur_src,
  output logic [DIVW-1:0] cur_div,
  output logic            clk_en_o
);
  localparam logic [NSRC-1:0] SRC_RST = NSRC'(1);

  logic [DIVW-1:0] cnt;
  logic            period_end;

  assign period_end = sel_tick && (cnt == cur_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cur_src  <= SRC_RST;
      cur_div  <= '0;
      clk_en_o <= 1'b0;
    end else begin
      clk_en_o <= period_end && !gate_off;
      if (period_end) begin
        cnt     <= '0;
        cur_src <= req_src;
        cur_div <= req_div;
      end else if (sel_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
  import pclk_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int DIVW = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NSRC-1:0] src_tick,
  output logic            clk_en_o,
  output logic [NSRC-1:0] src_in_use,
  output logic [DIVW-1:0] div_in_use
);
  logic [NSRC-1:0]  req_src;
  logic [DIVW-1:0]  req_div;
  logic [GATEW-1:0] gate_code;
  logic             gate_off;
  logic             sel_tick;

  pclk_regs #(.NSRC(NSRC), .DIVW(DIVW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cur_src(src_in_use), .cur_div(div_in_use),
    .req_src(req_src), .req_div(req_div), .gate_code(gate_code),
    .gate_off(gate_off), .rdata(rdata)
  );

  pclk_srcsel #(.NSRC(NSRC)) u_sel (
    .src_tick(src_tick), .cur_src(src_in_use), .sel_tick(sel_tick)
  );

  pclk_div #(.NSRC(NSRC), .DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .sel_tick(sel_tick), .gate_off(gate_off),
    .req_src(req_src), .req_div(req_div),
    .cur_src(src_in_use), .cur_div(div_in_use), .clk_en_o(clk_en_o)
  );
endmodule

// File: rtl/pclk_ctrl_chk.sv
module pclk_ctrl_chk #(
  parameter int NSRC = 4,
  parameter int DIVW = 4,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wdata,
  input logic [NSRC-1:0] src_tick,
  input logic            clk_en_o,
  input logic [NSRC-1:0] src_in_use,
  input logic [DIVW-1:0] div_in_use,
  input logic [NSRC-1:0] req_src,
  input logic [2:0]      gate_code
);
  logic src_wr_bad;
  assign src_wr_bad = wr_en && (addr == 2'd0) &&
                      (($countones(wdata[NSRC-1:0]) != 1) || ((wdata >> NSRC) != '0));

  // R10
  src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(src_in_use) == 1);

  // R4
  pulse_from_sel_chk: assert property (@(posedge clk) disable iff (rst)
    clk_en_o |-> $past(|(src_tick & src_in_use)));

  // R6
  status_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(src_in_use) || !$stable(div_in_use)) |-> $past(|(src_tick & src_in_use)));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(gate_code == 3'b111) |-> !clk_en_o);

  // R5
  bad_src_wr_chk: assert property (@(posedge clk) disable iff (rst)
    src_wr_bad |=> $stable(req_src));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_o && div_in_use != '0) |=> !clk_en_o);
endmodule

bind pclk_ctrl pclk_ctrl_chk #(.NSRC(NSRC), .DIVW(DIVW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .src_tick(src_tick), .clk_en_o(clk_en_o), .src_in_use(src_in_use),
  .div_in_use(div_in_use), .req_src(req_src), .gate_code(gate_code)
);

// File: tb/sim_pclk_ctrl.sv
`timescale 1ns/1ps
module sim_pclk_ctrl;
  localparam int NSRC = 4;
  localparam int DIVW = 4;
  localparam int DW   = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [1:0]      addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic [NSRC-1:0] src_tick = '0;
  logic            clk_en_o;
  logic [NSRC-1:0] src_in_use;
  logic [DIVW-1:0] div_in_use;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pclk_ctrl #(.NSRC(NSRC), .DIVW(DIVW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_tick(src_tick), .clk_en_o(clk_en_o),
    .src_in_use(src_in_use), .div_in_use(div_in_use)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; src_tick = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = int'(rdata);
  endtask

  // Drives n cycles of tick pattern tk and counts pulses on clk_en_o
  task automatic run(input logic [NSRC-1:0] tk, input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en_o) pulses++;
      src_tick = tk;
    end
    @(negedge clk);
    if (clk_en_o) pulses++;
    src_tick = '0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk("R1 clk_en_o", int'(clk_en_o), 0);
    chk("R1 src_in_use", int'(src_in_use), 1);
    chk("R1 div_in_use", int'(div_in_use), 0);
    rd(2'd0, v); chk("R1 src req", v, 1);
    rd(2'd1, v); chk("R1 div req", v, 0);
    rd(2'd2, v); chk("R1 gate", v, 0);
  endtask

  task automatic t_regmap();
    int v;
    do_reset();
    wr(2'd0, 8'h04); wr(2'd1, 8'h05); wr(2'd2, 8'h02);
    rd(2'd0, v); chk("R9 src field", v, 4);
    rd(2'd1, v); chk("R9 div field", v, 5);
    rd(2'd2, v); chk("R9 gate field", v, 2);
    rd(2'd3, v); chk("R9 status", v, 8'h01);
    run(4'b0001, 1, v);
    rd(2'd3, v); chk("R9 status after edge", v, 8'h54);
  endtask

  task automatic t_pass();
    int p;
    do_reset();
    run(4'b0001, 6, p); chk("R3 pulses per tick", p, 6);
    @(negedge clk); src_tick = 4'b0001;
    @(negedge clk); src_tick = '0; chk("R3 latency one", int'(clk_en_o), 1);
    @(negedge clk); chk("R3 single cycle", int'(clk_en_o), 0);
  endtask

  task automatic t_div();
    int p;
    do_reset();
    wr(2'd1, 8'd3);
    run(4'b0001, 13, p); chk("R2 divide by 4", p, 4);
    chk("R2 div_in_use", int'(div_in_use), 3);
    run(4'b0001, 8, p); chk("R2 divide by 4 again", p, 2);
  endtask

  task automatic t_srcsel();
    int p;
    do_reset();
    run(4'b1110, 5, p); chk("R4 other sources ignored", p, 0);
    chk("R4 status kept", int'(src_in_use), 1);
    run(4'b0001, 2, p); chk("R4 selected source counts", p, 2);
  endtask

  task automatic t_reject();
    int v;
    do_reset();
    wr(2'd0, 8'h03); rd(2'd0, v); chk("R5 two bits rejected", v, 1);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R5 zero rejected", v, 1);
    wr(2'd0, 8'h12); rd(2'd0, v); chk("R5 upper bit rejected", v, 1);
    wr(2'd0, 8'h08); rd(2'd0, v); chk("R5 one-hot accepted", v, 8);
    run(4'b0001, 1, v);
    chk("R5 status follows", int'(src_in_use), 8);
    chk("R10 one-hot status", $countones(src_in_use), 1);
  endtask

  task automatic t_boundary();
    int p;
    do_reset();
    wr(2'd1, 8'd2);
    run(4'b0001, 1, p); chk("R6 first edge pulse", p, 1);
    chk("R6 div loaded", int'(div_in_use), 2);
    wr(2'd0, 8'h02); wr(2'd1, 8'd1);
    chk("R6 src held", int'(src_in_use), 1);
    chk("R6 div held", int'(div_in_use), 2);
    run(4'b0010, 3, p); chk("R6 new src early ignored", p, 0);
    run(4'b0001, 2, p); chk("R6 mid period", p, 0);
    chk("R6 src still old", int'(src_in_use), 1);
    run(4'b0001, 1, p); chk("R6 closing pulse", p, 1);
    chk("R6 src switched", int'(src_in_use), 2);
    chk("R6 div switched", int'(div_in_use), 1);
    run(4'b0010, 4, p); chk("R6 new ratio", p, 2);
    chk("R10 one-hot", $countones(src_in_use), 1);
  endtask

  task automatic t_gate();
    int p;
    do_reset();
    wr(2'd2, 8'h07); wr(2'd1, 8'd4);
    run(4'b0001, 5, p); chk("R7 gated no pulses", p, 0);
    chk("R7 edge still loads", int'(div_in_use), 4);
    wr(2'd2, 8'h00);
    run(4'b0001, 5, p); chk("R7 ungated again", p, 1);
  endtask

  task automatic t_gate_other();
    int p;
    logic [2:0] codes [3] = '{3'b011, 3'b110, 3'b101};
    do_reset();
    for (int i = 0; i < 3; i++) begin
      wr(2'd2, {5'd0, codes[i]});
      run(4'b0001, 3, p); chk("R8 near code runs", p, 3);
    end
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_pass();
    t_div();
    t_srcsel();
    t_reject();
    t_boundary();
    t_gate();
    t_gate_other();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule